// File: doc/BRIEF.md
# Vectored Interrupt Controller with Non-Maskable Conversion Interrupt

This block arbitrates interrupt requests for a small 8-bit processor core. It holds two 8-bit control registers, each mixing enable bits and request flags, which the core reads and writes. Six maskable sources set flags: two external pins with a selectable active edge, two timer overflow pulses, a time base tick and a real-time clock tick. A seventh source, completion of an analog-to-digital conversion, is handled apart from the others: the global enable cannot mask it, and a full return stack does not hold it back.

At each instruction boundary signalled by the core, the controller picks at most one request. On the next cycle it presents a one-cycle call request with the vector address of the chosen handler. The return-address push and the stack are outside the block. The controller only receives the stack-full status, and when the stack is full, the core overwrites the oldest return address for a conversion interrupt. Taking a maskable request clears that request's flag and the global enable, so handlers do not nest unless software turns the global enable back on.

Top module: `vic_nmi`

## Requirements
- R1: While reset is asserted and on the cycle after it is released, both control registers read 0x00 and `call_req` is 0.
- R2: A write with `reg_sel`=0 loads control register 0 from `reg_wdata`. A write with `reg_sel`=1 loads control register 1, where bits 3 and 7 always read 0. `rd_sel` chooses which register appears on `rd_data`.
- R3: Register 0 bit 4 (pin 0 flag) and bit 5 (pin 1 flag) are set by a detected edge on their pin. The edge select is 00 for falling, 01 for rising, and 10 or 11 for both. The block compares each pin sample with the previous cycle's sample.
- R4: A pulse on `tmr0_ovf` sets register 0 bit 6. Pulses on `tmr1_ovf`, `tbase_tick` and `rtc_tick` set register 1 bits 4, 5 and 6. A flag is set whatever the state of the enables, and it stays set until it is cleared.
- R5: A maskable source is taken on a cycle only if all of the following hold: `insn_boundary` is 1, its flag is set, its own enable is set, register 0 bit 0 (global enable) is set, `stack_full` is 0, and no conversion interrupt is taken on that cycle. The own enables are register 0 bits 1, 2, 3 for pin 0, pin 1 and timer 0, and register 1 bits 0, 1, 2 for timer 1, time base and real-time clock. A request that is not taken keeps its flag.
- R6: Taking a maskable source clears its flag and the global enable at the same clock edge. This clear takes priority over a core write on that cycle.
- R7: When several maskable sources qualify, the order is pin 0 (vector 0x04), pin 1 (0x08), timer 0 (0x0C), timer 1 (0x10), time base (parameter, default 0x14) and real-time clock (parameter, default 0x18).
- R8: A falling edge on `adc_busy` while register 0 bit 7 is set makes a conversion request pending. The pending request is dropped whenever bit 7 is 0. It is taken at the next instruction boundary with vector 0x1C, whatever the global enable and `stack_full`, and ahead of any maskable source.
- R9: A hardware flag-setting event wins over a core write that clears the same flag on the same cycle.
- R10: `call_req` is high for one cycle after each cycle in which a request is taken, and only then, with `call_vector` holding the chosen vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 register 0, 1 register 1 |
| reg_wdata | input | 8 | Write data |
| rd_sel | input | 1 | Read select: 0 register 0, 1 register 1 |
| rd_data | output | 8 | Selected register contents |
| ext0_in | input | 1 | External request pin 0 |
| ext1_in | input | 1 | External request pin 1 |
| ext0_edge | input | 2 | Static edge select for pin 0 |
| ext1_edge | input | 2 | Static edge select for pin 1 |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| tbase_tick | input | 1 | Time base tick |
| rtc_tick | input | 1 | Real-time clock tick |
| adc_busy | input | 1 | Conversion in progress; a fall marks completion |
| stack_full | input | 1 | Return stack has no free level |
| insn_boundary | input | 1 | Core can accept a call this cycle |
| call_req | output | 1 | One-cycle call request |
| call_vector | output | 8 | Handler address for the call |

## Verification
The assertions assume that event inputs are single-cycle pulses or level samples taken on the clock, that the edge selects stay constant while a pin may be moving, and that the pins and `adc_busy` are held low during reset. Without that last condition, a level present at reset release would be read as an edge. The stimulus changes every input only on the falling clock edge and holds everything low in reset. It changes edge selects only at segment boundaries. It pushes `stack_full`, `insn_boundary`, the event pulses and core writes randomly, with a different bias in each segment, so that blocked, coincident and competing requests all occur.

// File: rtl/vic_nmi.sv
module vic_nmi #(
  parameter logic [7:0] VEC_TB  = 8'h14,
  parameter logic [7:0] VEC_RTC = 8'h18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  input  logic       ext0_in,
  input  logic       ext1_in,
  input  logic [1:0] ext0_edge,
  input  logic [1:0] ext1_edge,
  input  logic       tmr0_ovf,
  input  logic       tmr1_ovf,
  input  logic       tbase_tick,
  input  logic       rtc_tick,
  input  logic       adc_busy,
  input  logic       stack_full,
  input  logic       insn_boundary,
  output logic       call_req,
  output logic [7:0] call_vector
);

  localparam logic [7:0] VEC_ADC = 8'h1C;
  localparam logic [7:0] R1_MASK = 8'h77;

  logic [7:0] ctl0, ctl1, nxt0, nxt1;
  logic       ext0_q, ext1_q, busy_q, ad_pend;
  logic [5:0] req, grant;
  logic [7:0] mvec;

  function automatic logic edge_hit(input logic [1:0] m, input logic cur, input logic prev);
    case (m)
      2'b00:   return prev & ~cur;
      2'b01:   return ~prev & cur;
      default: return prev ^ cur;
    endcase
  endfunction

  wire ext0_evt = edge_hit(ext0_edge, ext0_in, ext0_q);
  wire ext1_evt = edge_hit(ext1_edge, ext1_in, ext1_q);
  wire ad_fall  = busy_q & ~adc_busy;

  assign req = {ctl1[6] & ctl1[2], ctl1[5] & ctl1[1], ctl1[4] & ctl1[0],
                ctl0[6] & ctl0[3], ctl0[5] & ctl0[2], ctl0[4] & ctl0[1]};
  assign grant = req & (~req + 6'd1);

  wire take_nmi  = insn_boundary & ad_pend & ctl0[7];
  wire take_mask = insn_boundary & ~take_nmi & ctl0[0] & ~stack_full & (|req);

  always_comb begin
    unique case (1'b1)
      grant[0]: mvec = 8'h04;
      grant[1]: mvec = 8'h08;
      grant[2]: mvec = 8'h0C;
      grant[3]: mvec = 8'h10;
      grant[4]: mvec = VEC_TB;
      grant[5]: mvec = VEC_RTC;
      default:  mvec = 8'h00;
    endcase
  end

  always_comb begin
    nxt0 = ctl0;
    nxt1 = ctl1;
    if (reg_we && !reg_sel) nxt0 = reg_wdata;
    if (reg_we &&  reg_sel) nxt1 = reg_wdata & R1_MASK;
    if (take_mask) begin
      nxt0[0] = 1'b0;
      if (grant[0]) nxt0[4] = 1'b0;
      if (grant[1]) nxt0[5] = 1'b0;
      if (grant[2]) nxt0[6] = 1'b0;
      if (grant[3]) nxt1[4] = 1'b0;
      if (grant[4]) nxt1[5] = 1'b0;
      if (grant[5]) nxt1[6] = 1'b0;
    end
    if (ext0_evt)   nxt0[4] = 1'b1;
    if (ext1_evt)   nxt0[5] = 1'b1;
    if (tmr0_ovf)   nxt0[6] = 1'b1;
    if (tmr1_ovf)   nxt1[4] = 1'b1;
    if (tbase_tick) nxt1[5] = 1'b1;
    if (rtc_tick)   nxt1[6] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl0        <= '0;
      ctl1        <= '0;
      ext0_q      <= 1'b0;
      ext1_q      <= 1'b0;
      busy_q      <= 1'b0;
      ad_pend     <= 1'b0;
      call_req    <= 1'b0;
      call_vector <= '0;
    end else begin
      ctl0     <= nxt0;
      ctl1     <= nxt1;
      ext0_q   <= ext0_in;
      ext1_q   <= ext1_in;
      busy_q   <= adc_busy;
      ad_pend  <= ctl0[7] & ((ad_pend & ~take_nmi) | ad_fall);
      call_req <= take_nmi | take_mask;
      if (take_nmi)       call_vector <= VEC_ADC;
      else if (take_mask) call_vector <= mvec;
    end
  end

  assign rd_data = rd_sel ? ctl1 : ctl0;

  a_r10_call_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> $past(insn_boundary));

  a_r5_no_mask_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && call_vector != VEC_ADC) |-> !$past(stack_full));

  a_r6_gie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && call_vector != VEC_ADC) |-> !ctl0[0]);

  a_r8_nmi_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_boundary && ad_pend && ctl0[7]) |=> (call_req && call_vector == VEC_ADC));

  a_r9_tmr0_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    tmr0_ovf |=> ctl0[6]);

  a_r9_rtc_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_tick |=> ctl1[6]);

  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl1[3] == 1'b0) && (ctl1[7] == 1'b0));

endmodule

// File: tb/vic_nmi_bench.sv
`timescale 1ns/1ps
module vic_nmi_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0, reg_sel = 1'b0, rd_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] rd_data;
  logic       ext0_in = 1'b0, ext1_in = 1'b0;
  logic [1:0] ext0_edge = 2'b00, ext1_edge = 2'b00;
  logic       tmr0_ovf = 1'b0, tmr1_ovf = 1'b0, tbase_tick = 1'b0, rtc_tick = 1'b0;
  logic       adc_busy = 1'b0, stack_full = 1'b0, insn_boundary = 1'b0;
  logic       call_req;
  logic [7:0] call_vector;

  vic_nmi u_vic_nmi (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .rd_sel(rd_sel), .rd_data(rd_data), .ext0_in(ext0_in), .ext1_in(ext1_in),
    .ext0_edge(ext0_edge), .ext1_edge(ext1_edge), .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
    .tbase_tick(tbase_tick), .rtc_tick(rtc_tick), .adc_busy(adc_busy),
    .stack_full(stack_full), .insn_boundary(insn_boundary),
    .call_req(call_req), .call_vector(call_vector));

  always #2 clk = ~clk;

  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // Reference model state
  logic [7:0] m_reg [2] = '{8'h00, 8'h00};
  bit   m_p0 = 0, m_p1 = 0, m_busy = 0, m_pend = 0, m_call = 0;
  int   m_vec = 0;
  localparam int FR [6] = '{0, 0, 0, 1, 1, 1};
  localparam int FB [6] = '{4, 5, 6, 4, 5, 6};
  localparam int EB [6] = '{1, 2, 3, 0, 1, 2};
  localparam int VV [6] = '{4, 8, 12, 16, 20, 24};

  function automatic bit saw_edge(int mode, bit cur, bit prev);
    if (mode == 0) return prev && !cur;
    if (mode == 1) return !prev && cur;
    return prev != cur;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg[0] = 0; m_reg[1] = 0; m_p0 = 0; m_p1 = 0; m_busy = 0;
      m_pend = 0; m_call = 0; m_vec = 0;
    end else begin
      bit ev [6];
      bit nmi;
      int win;
      bit new_pend;
      ev[0] = saw_edge(int'(ext0_edge), ext0_in, m_p0);
      ev[1] = saw_edge(int'(ext1_edge), ext1_in, m_p1);
      ev[2] = tmr0_ovf; ev[3] = tmr1_ovf; ev[4] = tbase_tick; ev[5] = rtc_tick;
      nmi = insn_boundary && m_pend && m_reg[0][7];
      win = -1;
      if (!nmi && insn_boundary && m_reg[0][0] && !stack_full)
        for (int k = 0; k < 6; k++)
          if (win < 0 && m_reg[FR[k]][FB[k]] && m_reg[FR[k]][EB[k]]) win = k;
      new_pend = m_reg[0][7] && ((m_pend && !nmi) || (m_busy && !adc_busy));
      if (reg_we) m_reg[reg_sel] = reg_sel ? (reg_wdata & 8'h77) : reg_wdata;
      if (win >= 0) begin
        m_reg[0][0] = 0;
        m_reg[FR[win]][FB[win]] = 0;
      end
      for (int k = 0; k < 6; k++) if (ev[k]) m_reg[FR[k]][FB[k]] = 1;
      m_pend = new_pend;
      m_call = nmi || (win >= 0);
      if (nmi) m_vec = 28;
      else if (win >= 0) m_vec = VV[win];
      m_p0 = ext0_in; m_p1 = ext1_in; m_busy = adc_busy;
    end
  end

  task automatic check(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    check("rd_data", int'(rd_data), int'(m_reg[rd_sel]));
    check("call_req", int'(call_req), int'(m_call));
    if (m_call) check("call_vector", int'(call_vector), m_vec);
  endtask

  task automatic quiet();
    reg_we = 0; tmr0_ovf = 0; tmr1_ovf = 0; tbase_tick = 0; rtc_tick = 0;
    insn_boundary = 0;
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    quiet();
    rd_sel = ~rd_sel;
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    step();
    reg_we = 1; reg_sel = sel; reg_wdata = d;
  endtask

  function automatic bit pr(int pct);
    return $urandom_range(99) < pct;
  endfunction

  task automatic rnd_seg(string t, int cycles, int p_ev, int p_wr, int p_full, int p_bnd, int p_adc);
    tag = t;
    ext0_edge = 2'($urandom_range(3));
    ext1_edge = 2'($urandom_range(3));
    for (int c = 0; c < cycles; c++) begin
      step();
      ext0_in    = pr(p_ev) ? ~ext0_in : ext0_in;
      ext1_in    = pr(p_ev) ? ~ext1_in : ext1_in;
      tmr0_ovf   = pr(p_ev);
      tmr1_ovf   = pr(p_ev);
      tbase_tick = pr(p_ev);
      rtc_tick   = pr(p_ev);
      adc_busy   = pr(p_adc) ? ~adc_busy : adc_busy;
      stack_full = pr(p_full);
      insn_boundary = pr(p_bnd);
      rd_sel = pr(50);
      if (pr(p_wr)) begin
        reg_we = 1;
        reg_sel = pr(50);
        reg_wdata = 8'($urandom);
        if (!reg_sel && pr(70)) reg_wdata[0] = 1'b1;
      end
    end
  endtask

  initial begin
    #50000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (4) @(negedge clk);
    check("reset rd0", int'(rd_data), 0);
    check("reset call", int'(call_req), 0);
    rd_sel = 1;
    @(negedge clk);
    check("reset rd1", int'(rd_data), 0);
    rst_n = 1;
    step(); step();

    // R2: register access, unused bits of register 1
    tag = "R2";
    wr(1, 8'hFF); step(); step();
    wr(0, 8'h5A); step(); step();
    wr(1, 8'h00); wr(0, 8'h00); step();

    // R3: edge select modes on both pins
    tag = "R3";
    for (int m = 0; m < 3; m++) begin
      ext0_edge = 2'(m); ext1_edge = 2'(m);
      step(); ext0_in = 1; step(); step(); ext1_in = 1; step(); step();
      ext0_in = 0; step(); step(); ext1_in = 0; step(); step();
      wr(0, 8'h00); step();
    end

    rnd_seg("R4", 1500, 20, 5, 0, 0, 0);
    rnd_seg("R5", 3000, 10, 20, 50, 40, 0);
    rnd_seg("R6 R7", 3000, 25, 30, 10, 50, 0);
    rnd_seg("R8", 3000, 10, 25, 60, 30, 20);
    rnd_seg("R9", 3000, 40, 60, 20, 30, 10);
    rnd_seg("R10", 3000, 15, 20, 20, 10, 10);
    step(); step();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule